// File: doc/BRIEF.md
# Chunk-Limited Legacy Instruction Decoder

This block is the issue stage of a legacy decode path for instructions that each produce one micro-op. It looks at the head of an instruction queue through a window of `WIDTH` entries. Each entry carries a start address, a byte length, a taken-branch flag and a branch target. Every cycle the block picks a decode group of up to `WIDTH` consecutive entries. All entries in a group must sit in the same aligned fetch chunk of `CHUNK_BYTES` bytes. It tells the queue how many head entries it consumed and presents the group, registered, on the next cycle.

An entry belongs to the chunk that holds its last byte, so an instruction that straddles a chunk edge counts as part of the later chunk. A group stops at a chunk change, at a taken branch, at a gap in the address sequence, or at an empty window slot. This makes loop cost depend on byte layout and not only on instruction count. The block also tracks the address it expects next. After reset this is a configured entry address; after a taken branch it is the branch target. A head entry at any other address is stale and is dropped.

Top module: `chunk_decoder`

## Requirements
- R1: In a cycle without stall, the group holds the longest run of up to WIDTH head entries that are valid and sequential. The first entry's address equals the expected address, and each later entry starts at the previous entry's address plus length. `pop_count` reports, combinationally, how many head entries are consumed.
- R2: All entries of a group lie in one chunk, the chunk index being (address + length − 1) divided by CHUNK_BYTES. Selection stops at the first entry whose chunk differs from the first entry's chunk.
- R3: An entry whose bytes cross a chunk edge belongs to the chunk of its last byte. It may therefore join a group whose other entries lie wholly in that later chunk, but never one in the earlier chunk.
- R4: A taken branch is the last entry of its group, and the expected address becomes its target.
- R5: After the clock edge at which a group is consumed, `grp_count`, `grp_chunk` and `grp_addr` show that group. Slot k of `grp_addr` holds entry k's address, and unused slots read 0.
- R6: While `stall` is high, `pop_count` is 0, the registered group outputs keep their values, and the expected address does not move.
- R7: After reset, `grp_count` is 0 and the expected address is ENTRY_ADDR. A valid head entry at another address is dropped alone: `pop_count` is 1 and the next group is empty.
- R8: With WIDTH=5, a loop of 16 one-byte entries that fills one chunk decodes as groups of 5, 5, 5 and 1 per iteration.
- R9: With WIDTH=4 and a loop top aligned to 32 bytes, take a body of a 2-byte first entry, one-byte middle entries and a 2-byte taken branch. Such a loop costs 9 cycles per iteration for 35 entries and 10 cycles for 36 entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Hold the current group and consume nothing |
| win_valid | input | WIDTH | Valid flag per head-window slot (slot 0 is the queue head) |
| win_addr | input | WIDTH*AW | Start address per slot |
| win_len | input | WIDTH*LEN_W | Byte length per slot, at least 1 |
| win_taken | input | WIDTH | Slot is a taken branch |
| win_target | input | WIDTH*AW | Branch target per slot |
| pop_count | output | CW | Head entries consumed this cycle |
| grp_count | output | CW | Number of entries in the registered group |
| grp_chunk | output | AW-log2(CHUNK_BYTES) | Chunk index of the registered group |
| grp_addr | output | WIDTH*AW | Addresses of the group slots, 0 when unused |

## Verification
The assertions assume that the queue presents a stable window for the whole cycle. They also assume it removes exactly `pop_count` entries at the edge, that every length is nonzero, and that addresses within a group do not wrap past the top of the address space. The stimulus keeps to this. The bench holds its own instruction stream and advances its read pointer by the count its model predicts. All loops are placed at low addresses well below the wrap point. Lengths are drawn between 1 and 6 bytes, and stale entries are placed only ahead of the first branch to the loop.

// File: rtl/chunkdec_pkg.sv
package chunkdec_pkg;

   // What the picker does with the queue head in a cycle
   typedef enum logic [1:0] {
      HEAD_IDLE  = 2'd0,   // nothing valid at the head
      HEAD_DROP  = 2'd1,   // head is stale, discard it alone
      HEAD_ISSUE = 2'd2    // head starts a decode group
   } head_act_e;

   // Bits needed to hold a count from 0 to n
   function automatic int unsigned count_bits(input int unsigned n);
      return (n < 1) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/cd_slot_span.sv
// Per-slot byte span: end address and owning chunk (chunk of the last byte).
module cd_slot_span #(
   parameter int AW    = 16,
   parameter int LEN_W = 4,
   parameter int SH    = 4,
   localparam int CHW  = AW - SH
) (
   input  logic [AW-1:0]    addr,
   input  logic [LEN_W-1:0] len,
   output logic [AW-1:0]    end_addr,
   output logic [CHW-1:0]   chunk
);
   logic [AW-1:0] last_byte;

   assign end_addr  = addr + AW'(len);
   assign last_byte = end_addr - AW'(1);
   assign chunk     = CHW'(last_byte >> SH);
endmodule

// File: rtl/cd_group_pick.sv
// Builds the decode group from the head window as a chain of slot links.
module cd_group_pick
   import chunkdec_pkg::*;
#(
   parameter int W   = 4,
   parameter int AW  = 16,
   parameter int CHW = 12,
   parameter int CW  = 3
) (
   input  logic [W-1:0]     valid,
   input  logic [W-1:0]     taken,
   input  logic [W*AW-1:0]  addr,
   input  logic [W*AW-1:0]  end_addr,
   input  logic [W*AW-1:0]  target,
   input  logic [W*CHW-1:0] chunk,
   input  logic [AW-1:0]    pc,
   output head_act_e        act,
   output logic [W-1:0]     take,
   output logic [CW-1:0]    take_cnt,
   output logic [AW-1:0]    pc_nxt,
   output logic [CHW-1:0]   head_chunk
);
   logic [W-1:0] link;

   assign head_chunk = chunk[CHW-1:0];

   for (genvar k = 0; k < W; k++) begin : g_link
      if (k == 0) begin : g_head
         assign link[k] = valid[0] && (addr[AW-1:0] == pc);
      end else begin : g_tail
         assign link[k] = link[k-1]
                        && !taken[k-1]
                        && valid[k]
                        && (addr[k*AW +: AW] == end_addr[(k-1)*AW +: AW])
                        && (chunk[k*CHW +: CHW] == chunk[CHW-1:0]);
      end
   end

   assign take = link;

   always_comb begin
      take_cnt = '0;
      for (int k = 0; k < W; k++) begin
         take_cnt = take_cnt + CW'(link[k]);
      end
   end

   always_comb begin
      pc_nxt = pc;
      for (int k = 0; k < W; k++) begin
         if (link[k]) begin
            pc_nxt = taken[k] ? target[k*AW +: AW] : end_addr[k*AW +: AW];
         end
      end
   end

   always_comb begin
      if (!valid[0])    act = HEAD_IDLE;
      else if (link[0]) act = HEAD_ISSUE;
      else              act = HEAD_DROP;
   end
endmodule

// File: rtl/cd_fetch_pc.sv
// Expected-address register: entry address after reset, then follows groups.
module cd_fetch_pc #(
   parameter int AW = 16,
   parameter logic [AW-1:0] ENTRY_ADDR = AW'(128)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          upd,
   input  logic [AW-1:0] nxt,
   output logic [AW-1:0] pc
);
   always_ff @(posedge clk) begin
      if (rst)      pc <= ENTRY_ADDR;
      else if (upd) pc <= nxt;
   end

   // R7: the first cycle out of reset expects the entry address
   assert_entry_after_reset_R7: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (pc == ENTRY_ADDR));

   // R6: with no update the expected address stays put
   assert_pc_hold_R6: assert property (@(posedge clk) disable iff (rst)
      !upd |=> $stable(pc));
endmodule

// File: rtl/chunk_decoder.sv
module chunk_decoder
   import chunkdec_pkg::*;
#(
   parameter int WIDTH       = 4,
   parameter int AW          = 16,
   parameter int LEN_W       = 4,
   parameter int CHUNK_BYTES = 16,
   parameter logic [AW-1:0] ENTRY_ADDR = AW'(128),
   localparam int SH  = $clog2(CHUNK_BYTES),
   localparam int CHW = AW - SH,
   localparam int CW  = count_bits(WIDTH)
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   stall,
   input  logic [WIDTH-1:0]       win_valid,
   input  logic [WIDTH*AW-1:0]    win_addr,
   input  logic [WIDTH*LEN_W-1:0] win_len,
   input  logic [WIDTH-1:0]       win_taken,
   input  logic [WIDTH*AW-1:0]    win_target,
   output logic [CW-1:0]          pop_count,
   output logic [CW-1:0]          grp_count,
   output logic [CHW-1:0]         grp_chunk,
   output logic [WIDTH*AW-1:0]    grp_addr
);
   // ---------------- elaboration checks ----------------
   if (WIDTH < 1 || WIDTH > 8) begin : g_bad_width
      $error("chunk_decoder: WIDTH must be 1..8");
   end
   if (CHUNK_BYTES < 2 || (CHUNK_BYTES & (CHUNK_BYTES - 1)) != 0) begin : g_bad_chunk
      $error("chunk_decoder: CHUNK_BYTES must be a power of two >= 2");
   end
   if (LEN_W < 1 || LEN_W >= AW || (1 << LEN_W) > 2 * CHUNK_BYTES) begin : g_bad_len
      $error("chunk_decoder: LEN_W out of range");
   end
   if (SH >= AW) begin : g_bad_aw
      $error("chunk_decoder: AW too small for CHUNK_BYTES");
   end

   // ---------------- per-slot spans ----------------
   logic [WIDTH*AW-1:0]  slot_end;
   logic [WIDTH*CHW-1:0] slot_chunk;

   for (genvar k = 0; k < WIDTH; k++) begin : g_span
      cd_slot_span #(.AW(AW), .LEN_W(LEN_W), .SH(SH)) span_i (
         .addr     (win_addr[k*AW +: AW]),
         .len      (win_len[k*LEN_W +: LEN_W]),
         .end_addr (slot_end[k*AW +: AW]),
         .chunk    (slot_chunk[k*CHW +: CHW])
      );
   end

   // ---------------- group selection ----------------
   logic [AW-1:0]  pc, pc_nxt;
   head_act_e      act;
   logic [WIDTH-1:0] take;
   logic [CW-1:0]  take_cnt;
   logic [CHW-1:0] head_chunk;

   cd_group_pick #(.W(WIDTH), .AW(AW), .CHW(CHW), .CW(CW)) pick_i (
      .valid      (win_valid),
      .taken      (win_taken),
      .addr       (win_addr),
      .end_addr   (slot_end),
      .target     (win_target),
      .chunk      (slot_chunk),
      .pc         (pc),
      .act        (act),
      .take       (take),
      .take_cnt   (take_cnt),
      .pc_nxt     (pc_nxt),
      .head_chunk (head_chunk)
   );

   logic pc_upd;
   assign pc_upd = !stall && (act == HEAD_ISSUE);

   cd_fetch_pc #(.AW(AW), .ENTRY_ADDR(ENTRY_ADDR)) pc_i (
      .clk (clk),
      .rst (rst),
      .upd (pc_upd),
      .nxt (pc_nxt),
      .pc  (pc)
   );

   always_comb begin
      if (stall)                  pop_count = '0;
      else if (act == HEAD_DROP)  pop_count = CW'(1);
      else                        pop_count = take_cnt;
   end

   // ---------------- registered group ----------------
   always_ff @(posedge clk) begin
      if (rst) begin
         grp_count <= '0;
         grp_chunk <= '0;
         grp_addr  <= '0;
      end else if (!stall) begin
         grp_count <= (act == HEAD_ISSUE) ? take_cnt : '0;
         if (act == HEAD_ISSUE) grp_chunk <= head_chunk;
         for (int k = 0; k < WIDTH; k++) begin
            grp_addr[k*AW +: AW] <= take[k] ? win_addr[k*AW +: AW] : '0;
         end
      end
   end

   // ---------------- assertions ----------------
   assert_no_pop_on_stall_R6: assert property (@(posedge clk) disable iff (rst)
      stall |-> (pop_count == '0));

   assert_hold_on_stall_R6: assert property (@(posedge clk) disable iff (rst)
      stall |=> ($stable(grp_count) && $stable(grp_chunk) && $stable(grp_addr)));

   assert_drop_empty_R7: assert property (@(posedge clk) disable iff (rst)
      (win_valid[0] && (win_addr[AW-1:0] != pc) && !stall) |=> (grp_count == '0));

   assert_reset_empty_R7: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (grp_count == '0));

   assert_width_bound_R1: assert property (@(posedge clk) disable iff (rst)
      grp_count <= CW'(WIDTH));

   for (genvar k = 1; k < WIDTH; k++) begin : g_slot_chk
      assert_ascending_R1: assert property (@(posedge clk) disable iff (rst)
         (CW'(k) < grp_count) |->
            (grp_addr[k*AW +: AW] > grp_addr[(k-1)*AW +: AW]));

      assert_same_chunk_R2: assert property (@(posedge clk) disable iff (rst)
         (CW'(k) < grp_count) |->
            (CHW'(grp_addr[k*AW +: AW] >> SH) == grp_chunk));
   end
endmodule

// File: tb/chunk_decoder_tb_top.sv
module chunk_decoder_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int AW   = 16;
   localparam int LW   = 4;
   localparam int MAXS = 512;
   localparam logic [15:0] ENTRY = 16'h0080;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic rst, stall4, stall5;

   // instruction stream
   logic [15:0] s_addr [MAXS];
   logic [3:0]  s_len  [MAXS];
   logic        s_tak  [MAXS];
   logic [15:0] s_tgt  [MAXS];
   int slen;
   int ptr4, ptr5;
   int body_len [64];

   // lane windows
   logic [3:0]  v4, t4;  logic [63:0] a4, g4t;  logic [15:0] l4;
   logic [4:0]  v5, t5;  logic [79:0] a5, g5t;  logic [19:0] l5;

   always_comb begin
      v4 = '0; t4 = '0; a4 = '0; g4t = '0; l4 = '0;
      for (int k = 0; k < 4; k++) begin
         if (ptr4 + k < slen) begin
            v4[k] = 1'b1; t4[k] = s_tak[ptr4+k];
            a4[k*16 +: 16] = s_addr[ptr4+k]; g4t[k*16 +: 16] = s_tgt[ptr4+k];
            l4[k*4 +: 4] = s_len[ptr4+k];
         end
      end
   end
   always_comb begin
      v5 = '0; t5 = '0; a5 = '0; g5t = '0; l5 = '0;
      for (int k = 0; k < 5; k++) begin
         if (ptr5 + k < slen) begin
            v5[k] = 1'b1; t5[k] = s_tak[ptr5+k];
            a5[k*16 +: 16] = s_addr[ptr5+k]; g5t[k*16 +: 16] = s_tgt[ptr5+k];
            l5[k*4 +: 4] = s_len[ptr5+k];
         end
      end
   end

   logic [2:0] pop4, cnt4, pop5, cnt5;
   logic [11:0] ch4, ch5;
   logic [63:0] ga4;
   logic [79:0] ga5;

   chunk_decoder #(.WIDTH(4), .AW(AW), .LEN_W(LW), .CHUNK_BYTES(16), .ENTRY_ADDR(ENTRY)) dut_i (
      .clk(clk), .rst(rst), .stall(stall4),
      .win_valid(v4), .win_addr(a4), .win_len(l4), .win_taken(t4), .win_target(g4t),
      .pop_count(pop4), .grp_count(cnt4), .grp_chunk(ch4), .grp_addr(ga4));

   chunk_decoder #(.WIDTH(5), .AW(AW), .LEN_W(LW), .CHUNK_BYTES(16), .ENTRY_ADDR(ENTRY)) dut5_i (
      .clk(clk), .rst(rst), .stall(stall5),
      .win_valid(v5), .win_addr(a5), .win_len(l5), .win_taken(t5), .win_target(g5t),
      .pop_count(pop5), .grp_count(cnt5), .grp_chunk(ch5), .grp_addr(ga5));

   int total = 0, bad = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // ---------------- stream building ----------------
   task automatic add(input logic [15:0] a, input int l, input bit t, input logic [15:0] tg);
      s_addr[slen] = a; s_len[slen] = 4'(l); s_tak[slen] = t; s_tgt[slen] = tg;
      slen++;
   endtask

   task automatic build_loop(input logic [15:0] base, input int n, input int iters, input int stale);
      logic [15:0] a;
      slen = 0;
      for (int i = 0; i < stale; i++) add(16'h0040 + 16'(i*4), 1, 1'b0, 16'h0);
      add(ENTRY, 2, 1'b1, base);
      for (int it = 0; it < iters; it++) begin
         a = base;
         for (int i = 0; i < n; i++) begin
            add(a, body_len[i], (i == n-1), base);
            a = a + 16'(body_len[i]);
         end
      end
   endtask

   // ---------------- reference model ----------------
   task automatic model_step(input int ptr, input int w, input logic [15:0] pc,
                             output int pop, output int cnt, output logic [11:0] chunk,
                             output logic [15:0] first, output logic [15:0] npc);
      logic [15:0] expa, e, lastb;
      pop = 0; cnt = 0; chunk = '0; first = '0; npc = pc;
      if (ptr >= slen) return;
      if (s_addr[ptr] != pc) begin pop = 1; return; end
      first = s_addr[ptr];
      lastb = s_addr[ptr] + 16'(s_len[ptr]) - 16'd1;
      chunk = lastb[15:4];
      expa = pc;
      for (int i = 0; i < w; i++) begin
         if (ptr + i >= slen) break;
         if (s_addr[ptr+i] != expa) break;
         e = s_addr[ptr+i] + 16'(s_len[ptr+i]);
         lastb = e - 16'd1;
         if (lastb[15:4] != chunk) break;
         cnt++;
         npc = s_tak[ptr+i] ? s_tgt[ptr+i] : e;
         expa = e;
         if (s_tak[ptr+i]) break;
      end
      pop = cnt;
   endtask

   // ---------------- scenario runner ----------------
   int e4c, e5c; logic [11:0] e4h, e5h; logic [15:0] e4f, e5f;
   logic [15:0] pc4, pc5;
   int grp4, grp5, n4, n5;
   int seq4c [16]; int seq5c [16]; logic [15:0] seq4a [16];

   task automatic compare_outputs(input bit first_cyc);
      string rq;
      rq = first_cyc ? "R7" : "R5";
      chk(cnt4 == 3'(e4c), rq, "w4 grp_count", cnt4, e4c);
      chk(cnt5 == 3'(e5c), rq, "w5 grp_count", cnt5, e5c);
      if (e4c > 0) begin
         chk(ch4 == e4h, "R2", "w4 grp_chunk", ch4, e4h);
         chk(ga4[15:0] == e4f, "R5", "w4 slot0 addr", ga4[15:0], e4f);
      end
      if (e5c > 0) begin
         chk(ch5 == e5h, "R2", "w5 grp_chunk", ch5, e5h);
         chk(ga5[15:0] == e5f, "R5", "w5 slot0 addr", ga5[15:0], e5f);
      end
   endtask

   task automatic run_scn(input bit rnd_stall);
      int p4, c4, p5, c5, cyc;
      logic [11:0] h4, h5; logic [15:0] f4, f5, np4, np5;
      string rq;
      rst = 1'b1; stall4 = 1'b0; stall5 = 1'b0;
      ptr4 = 0; ptr5 = 0; pc4 = ENTRY; pc5 = ENTRY;
      e4c = 0; e5c = 0; e4h = '0; e5h = '0; e4f = '0; e5f = '0;
      grp4 = 0; grp5 = 0; n4 = 0; n5 = 0;
      repeat (2) @(posedge clk);
      #1 rst = 1'b0;
      cyc = 0;
      while ((ptr4 < slen || ptr5 < slen) && cyc < 4000) begin
         @(negedge clk);
         compare_outputs(cyc == 0);
         model_step(ptr4, 4, pc4, p4, c4, h4, f4, np4);
         model_step(ptr5, 5, pc5, p5, c5, h5, f5, np5);
         rq = stall4 ? "R6" : ((p4 == 1 && c4 == 0) ? "R7" : "R1");
         chk(pop4 == 3'(stall4 ? 0 : p4), rq, "w4 pop_count", pop4, stall4 ? 0 : p4);
         rq = stall5 ? "R6" : ((p5 == 1 && c5 == 0) ? "R7" : "R1");
         chk(pop5 == 3'(stall5 ? 0 : p5), rq, "w5 pop_count", pop5, stall5 ? 0 : p5);
         @(posedge clk);
         #1;
         if (!stall4) begin
            e4c = c4; if (c4 > 0) begin e4h = h4; e4f = f4; end
            ptr4 += p4; pc4 = np4;
            if (c4 > 0) begin
               grp4++;
               if (n4 < 16) begin seq4c[n4] = c4; seq4a[n4] = f4; n4++; end
            end
         end
         if (!stall5) begin
            e5c = c5; if (c5 > 0) begin e5h = h5; e5f = f5; end
            ptr5 += p5; pc5 = np5;
            if (c5 > 0) begin
               grp5++;
               if (n5 < 16) begin seq5c[n5] = c5; n5++; end
            end
         end
         stall4 = rnd_stall && ($urandom % 4 == 0);
         stall5 = rnd_stall && ($urandom % 4 == 0);
         cyc++;
      end
      @(negedge clk);
      compare_outputs(1'b0);
      if (cyc >= 4000) chk(1'b0, "R1", "scenario watchdog", cyc, 4000);
      stall4 = 1'b0; stall5 = 1'b0;
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #(CLK_PERIOD * 190000);
      bad++; total++;
      $display("FAIL R1 watchdog expired actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   // ---------------- main ----------------
   initial begin
      int n;
      void'($urandom(32'd20240611));
      rst = 1'b1; stall4 = 1'b0; stall5 = 1'b0; slen = 0; ptr4 = 0; ptr5 = 0;

      // R9: 35-entry loop, two stale heads (R7), 3 iterations
      body_len[0] = 2; for (int i = 1; i < 34; i++) body_len[i] = 1; body_len[34] = 2;
      build_loop(16'h0100, 35, 3, 2);
      run_scn(1'b0);
      chk(grp4 == 1 + 3*9, "R9", "w4 decode cycles N=35", grp4, 28);
      chk(seq4a[1] == 16'h0100, "R4", "group after taken jump starts at target", seq4a[1], 16'h0100);
      chk(seq4c[0] == 1, "R4", "taken jump ends its group", seq4c[0], 1);

      // R9: 36-entry loop
      body_len[0] = 2; for (int i = 1; i < 35; i++) body_len[i] = 1; body_len[35] = 2;
      build_loop(16'h0100, 36, 3, 0);
      run_scn(1'b0);
      chk(grp4 == 1 + 3*10, "R9", "w4 decode cycles N=36", grp4, 31);

      // R8: 16 one-byte entries filling one chunk
      for (int i = 0; i < 16; i++) body_len[i] = 1;
      build_loop(16'h0100, 16, 2, 0);
      run_scn(1'b0);
      chk(seq5c[1] == 5, "R8", "w5 group 1", seq5c[1], 5);
      chk(seq5c[2] == 5, "R8", "w5 group 2", seq5c[2], 5);
      chk(seq5c[3] == 5, "R8", "w5 group 3", seq5c[3], 5);
      chk(seq5c[4] == 1, "R8", "w5 group 4", seq5c[4], 1);
      chk(grp5 == 1 + 2*4, "R8", "w5 decode cycles", grp5, 9);
      chk(grp4 == 1 + 2*4, "R1", "w4 decode cycles 16x1B", grp4, 9);

      // R3: a 3-byte entry at 0x10e straddles into chunk 0x11
      for (int i = 0; i < 14; i++) body_len[i] = 1;
      body_len[14] = 3; body_len[15] = 1;
      build_loop(16'h0100, 16, 1, 0);
      run_scn(1'b0);
      chk(seq4c[4] == 2, "R3", "w4 group before straddler", seq4c[4], 2);
      chk(seq4c[5] == 2, "R3", "w4 straddler joins later chunk", seq4c[5], 2);
      chk(seq4a[5] == 16'h010e, "R3", "w4 straddler leads its group", seq4a[5], 16'h010e);

      // random loops with random stalls (R6) and stale heads (R7)
      for (int s = 0; s < 10; s++) begin
         n = 3 + int'($urandom % 38);
         for (int i = 0; i < n; i++) body_len[i] = 1 + int'($urandom % 6);
         body_len[n-1] = 2;
         build_loop(16'h0100 + 16'($urandom % 32), n, 3, int'($urandom % 3));
         run_scn(1'b1);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule